// File: doc/BRIEF.md
# Adaptive Pulse-Train Buck Regulation Core

This block is the digital decision core of a buck converter whose output is sensed by a delay line. The delay line is powered from the converter output, so its propagation speed follows the output voltage. Once per reference period, a sampling strobe captures the parallel state of all delay-line taps. One tap is designated the sense tap, and its captured value decides whether the inductor charges or discharges. Three adjacent-tap comparisons around the sense tap locate the edge of the reference clock. If the edge lies in that narrow window, the loop is near regulation.

Near regulation, the block splits each charging phase into short bursts by ANDing the charge decision with an internally generated pulse train. This lowers the peak inductor current and the output ripple. Away from regulation, the pulse train is bypassed so the converter charges at full strength and recovers quickly. The pulse train comes from a counter in the system clock domain with a programmable period and high time. The decision and the mode are held between strobes. The gate command follows the held decision, the mode and the live pulse without any register delay.

Top module: `apt_buck_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `gate_o`, `err_o` and `steady_o` are 0.
- R2: On a strobe, when tap 20 (bit 19 of `taps_i`, where bit i holds tap i+1) is 1, `err_o` becomes 1 one clock later, which commands charging.
- R3: On a strobe, when tap 20 is 0, `err_o` becomes 0 one clock later, which commands discharging.
- R4: On a strobe, `steady_o` becomes 1 when any of these bit pairs of `taps_i` differ: 18/19, 19/20 or 20/21. These are the edge positions at taps 19, 20 and 21.
- R5: On a strobe where all three of those pairs are equal, `steady_o` becomes 0 (transient mode).
- R6: Without a strobe, changes on `taps_i` have no effect on `err_o`, `steady_o` or `gate_o`.
- R7: In transient mode, `gate_o` equals `err_o` on every cycle.
- R8: In steady mode, `gate_o` is `err_o` AND the pulse train, so it is never 1 while `err_o` is 0.
- R9: With high time H < period P, the pulse train repeats every P clocks and is 1 for H consecutive clocks of each period. H = 0 keeps it at 0.
- R10: With H >= P, the pulse train is constantly 1, so in steady mode `gate_o` equals `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe that captures the tap vector |
| taps_i | input | NUM_TAPS | Delay-line tap states; bit i is tap i+1 |
| pulse_period_i | input | CNT_W | Pulse-train period in clock cycles |
| pulse_high_i | input | CNT_W | Pulse-train high time in clock cycles |
| gate_o | output | 1 | High-side gate command (1 = charge, 0 = low side on) |
| err_o | output | 1 | Held charge/discharge decision |
| steady_o | output | 1 | Held mode flag (1 = near regulation, 0 = transient) |

## Verification
The bench builds the block with 22 taps, sense tap 20 and a one-tap window, so tap vectors for every edge position are short literals. The pulse counter is narrowed to 4 bits. With that width, periods of 3 to 5 and high times of 0, below, equal to and above the period can all be reached within a few dozen cycles. The pulse-train checks count high cycles over whole periods and the longest high run, so they do not depend on the counter's phase when the strobe lands.

// File: rtl/apt_pkg.sv
// Shared types for the adaptive pulse-train regulation core.
// Assumes nothing beyond a single system clock domain.
package apt_pkg;

    // Loop operating mode as held between sampling strobes.
    typedef enum logic {
        MODE_TRANSIENT = 1'b0,
        MODE_STEADY    = 1'b1
    } loop_mode_e;

endpackage

// File: rtl/apt_tap_sampler.sv
// Captures the delay-line tap vector on each sampling strobe and derives the
// charge decision (sense tap value) and the loop mode (edge found inside a
// window of adjacent taps around the sense tap). Both are held until the next
// strobe. Assumes the strobe is synchronous to clk and the taps are stable
// when it is high.
module apt_tap_sampler
    import apt_pkg::*;
#(
    parameter int NUM_TAPS  = 22,
    parameter int SENSE_TAP = 20,   // 1-based tap that decides charge/discharge
    parameter int WIN_HALF  = 1     // edge window spans SENSE_TAP +/- WIN_HALF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_stb,
    input  logic [NUM_TAPS-1:0] taps_i,
    output logic                err_q,
    output loop_mode_e          mode_q
);
    localparam int WIN_LO   = SENSE_TAP - WIN_HALF;
    localparam int WIN_HI   = SENSE_TAP + WIN_HALF;
    localparam int WIN_SIZE = WIN_HI - WIN_LO + 1;

    logic [WIN_SIZE-1:0] edge_hit;
    logic                near_reg;

    // One XOR per window position: tap k differs from tap k+1.
    for (genvar j = 0; j < WIN_SIZE; j++) begin : g_edge
        localparam int K = WIN_LO + j;
        assign edge_hit[j] = taps_i[K-1] ^ taps_i[K];
    end

    // Any hit inside the window means the loop is near regulation.
    assign near_reg = |edge_hit;

    // Capture decision and mode on the strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            mode_q <= MODE_TRANSIENT;
        end else if (sample_stb) begin
            err_q  <= taps_i[SENSE_TAP-1];
            mode_q <= near_reg ? MODE_STEADY : MODE_TRANSIENT;
        end
    end

    assert_err_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> err_q == $past(taps_i[SENSE_TAP-1]))
        else $error("err_q did not follow sense tap");

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(err_q) && $stable(mode_q))
        else $error("held state changed without strobe");

    assert_transient_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && taps_i[WIN_HI:WIN_LO-1] == {(WIN_SIZE+1){taps_i[WIN_LO-1]}})
        |=> mode_q == MODE_TRANSIENT)
        else $error("uniform window did not give transient mode");

endmodule

// File: rtl/apt_pulse_gen.sv
// Free-running pulse-train generator in the system clock domain. A counter
// runs 0..period-1; the output is 1 while the count is below the high time.
// A high time at or above the period forces a constant 1. Assumes the
// settings change rarely; a period shrink below the current count wraps.
module apt_pulse_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] high_i,
    output logic             pulse_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic             wrap;
    logic             force_on;

    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
    // Wrap when the next count would reach the period (period 0 wraps always).
    assign wrap     = cnt_inc >= {1'b0, period_i};
    assign force_on = high_i >= period_i;

    // Advance the phase counter, clearing on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_inc[CNT_W-1:0];
    end

    // Pulse is high during the first high_i counts, or always when forced.
    always_comb begin
        pulse_o = force_on || (cnt_q < high_i);
    end

    assert_count_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> cnt_q == $past(cnt_q) + 1'b1)
        else $error("pulse counter failed to advance");

    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt_q == '0)
        else $error("pulse counter failed to wrap");

endmodule

// File: rtl/apt_gate_mux.sv
// Selects the gate command: the held decision alone in transient mode, or the
// decision gated by the pulse train in steady mode. Purely combinational so
// the gate follows the live pulse without a register delay.
module apt_gate_mux
    import apt_pkg::*;
(
    input  logic       err_i,
    input  loop_mode_e mode_i,
    input  logic       pulse_i,
    output logic       gate_o
);
    // Apply the pulse train only near regulation.
    always_comb begin
        if (mode_i == MODE_STEADY) gate_o = err_i & pulse_i;
        else                       gate_o = err_i;
    end

endmodule

// File: rtl/apt_buck_ctrl.sv
// Top of the adaptive pulse-train regulation core. Samples the delay-line
// taps on each strobe, holds the charge decision and the mode, and drives the
// gate command with or without pulse-train chopping. Assumes all inputs are
// synchronous to clk.
module apt_buck_ctrl
    import apt_pkg::*;
#(
    parameter int NUM_TAPS  = 22,
    parameter int SENSE_TAP = 20,
    parameter int WIN_HALF  = 1,
    parameter int CNT_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_stb,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  logic [CNT_W-1:0]    pulse_period_i,
    input  logic [CNT_W-1:0]    pulse_high_i,
    output logic                gate_o,
    output logic                err_o,
    output logic                steady_o
);
    logic       err_q;
    loop_mode_e mode_q;
    logic       pulse;

    apt_tap_sampler #(
        .NUM_TAPS  (NUM_TAPS),
        .SENSE_TAP (SENSE_TAP),
        .WIN_HALF  (WIN_HALF)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .taps_i     (taps_i),
        .err_q      (err_q),
        .mode_q     (mode_q)
    );

    apt_pulse_gen #(
        .CNT_W (CNT_W)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (pulse_period_i),
        .high_i   (pulse_high_i),
        .pulse_o  (pulse)
    );

    apt_gate_mux u_mux (
        .err_i   (err_q),
        .mode_i  (mode_q),
        .pulse_i (pulse),
        .gate_o  (gate_o)
    );

    assign err_o    = err_q;
    assign steady_o = (mode_q == MODE_STEADY);

    assert_no_charge_without_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> !gate_o)
        else $error("gate on while decision is discharge");

    assert_transient_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !steady_o |-> gate_o == err_o)
        else $error("transient gate differs from decision");

    assert_forced_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (steady_o && err_o && pulse_high_i >= pulse_period_i) |-> gate_o)
        else $error("forced pulse did not hold gate on");

    assert_reset_release_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !gate_o && !err_o && !steady_o)
        else $error("outputs not cleared after reset");

endmodule

// File: tb/apt_buck_ctrl_bench.sv
module apt_buck_ctrl_bench;
    localparam int NT = 22;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [NT-1:0] taps = '0;
    logic [CW-1:0] per = 4'd4;
    logic [CW-1:0] hig = 4'd4;
    logic          gate, err, steady;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    apt_buck_ctrl #(.NUM_TAPS(NT), .SENSE_TAP(20), .WIN_HALF(1), .CNT_W(CW)) u_apt_buck_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_stb(stb), .taps_i(taps),
        .pulse_period_i(per), .pulse_high_i(hig),
        .gate_o(gate), .err_o(err), .steady_o(steady)
    );

    // {taps, expected err, expected steady}
    localparam logic [NT+1:0] VEC [9] = '{
        {22'h380000, 1'b1, 1'b1},  // edge at tap 19
        {22'h300000, 1'b0, 1'b1},  // edge at tap 20
        {22'h200000, 1'b0, 1'b1},  // edge at tap 21
        {22'h3C0000, 1'b1, 1'b0},  // edge at tap 18
        {22'h000000, 1'b0, 1'b0},  // edge passed all taps
        {22'h3FFFFF, 1'b1, 1'b0},  // no edge yet
        {22'h3FFFE0, 1'b1, 1'b0},  // edge far early
        {22'h100000, 1'b0, 1'b1},  // isolated bit 20
        {22'h080000, 1'b1, 1'b1}   // isolated bit 19
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [NT-1:0] t);
        @(negedge clk);
        taps = t;
        stb  = 1'b1;
        @(negedge clk);
        stb  = 1'b0;
    endtask

    // Count gate-high cycles over n samples and the longest high run.
    task automatic watch(input int n, output int highs, output int run_max);
        int run = 0;
        highs = 0;
        run_max = 0;
        for (int i = 0; i < n; i++) begin
            if (gate) begin
                highs++;
                run++;
                if (run > run_max) run_max = run;
            end else begin
                run = 0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int h, r;
        @(negedge clk);
        @(negedge clk);
        chk("R1 gate in reset", gate, 0);
        chk("R1 err in reset", err, 0);
        chk("R1 steady in reset", steady, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gate after release", gate, 0);
        chk("R1 steady after release", steady, 0);

        // Vector walk with a constant-1 pulse train (H == P).
        for (int v = 0; v < 9; v++) begin
            strobe(VEC[v][NT+1:2]);
            chk("R2/R3 err", err, int'(VEC[v][1]));
            chk("R4/R5 steady", steady, int'(VEC[v][0]));
            chk("R7/R10 gate", gate, int'(VEC[v][1]));
        end

        // R9: steady, charging, P=5 H=2.
        per = 4'd5; hig = 4'd2;
        strobe(22'h380000);
        watch(5, h, r);  chk("R9 highs per period", h, 2);
        watch(15, h, r); chk("R9 highs in three periods", h, 6);
        chk("R9 longest run", r, 2);

        // R9: P=3 H=1.
        per = 4'd3; hig = 4'd1;
        @(negedge clk);
        watch(9, h, r);  chk("R9 P3 highs", h, 3);
        chk("R9 P3 longest run", r, 1);

        // R9: H=0 keeps gate off in steady mode.
        hig = 4'd0;
        @(negedge clk);
        watch(8, h, r);  chk("R9 zero high time", h, 0);

        // R10: H == P and H > P give a constant gate.
        per = 4'd5; hig = 4'd5;
        @(negedge clk);
        watch(10, h, r); chk("R10 H equal P", h, 10);
        hig = 4'd7;
        @(negedge clk);
        watch(10, h, r); chk("R10 H above P", h, 10);

        // R7: transient, charging ignores pulse train.
        hig = 4'd2;
        strobe(22'h3FFFFF);
        watch(10, h, r); chk("R7 transient full charge", h, 10);

        // R8: steady, discharge never gates on.
        strobe(22'h300000);
        watch(10, h, r); chk("R8 steady discharge", h, 0);

        // R6: taps change without strobe.
        strobe(22'h380000);
        taps = 22'h000000;
        repeat (3) @(negedge clk);
        chk("R6 err held", err, 1);
        chk("R6 steady held", steady, 1);
        hig = 4'd5;
        @(negedge clk);
        watch(5, h, r); chk("R6 gate held", h, 5);

        // R1: reset mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 gate mid reset", gate, 0);
        chk("R1 err mid reset", err, 0);
        chk("R1 steady mid reset", steady, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gate after second release", gate, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule